// File: doc/BRIEF.md
# T1 Receive Line Alarm Detector

This block watches the recovered DS1 receive bit stream together with the frame timing supplied by the framer, and raises the line alarm flags: loss of signal, alarm indication signal (blue alarm), yellow alarm from the channel bit 2 method, and yellow alarm from the repeating pattern on the extended superframe data link. The framer supplies a bit strobe, the received bit, a marker for the framing bit that opens each 193-bit frame, a marker for bit position 2 of each DS0 channel, a data-link bit marker, the out-of-frame status and the extended superframe mode select. Frame alignment itself is done elsewhere.

While loss of signal is active, both receive rail outputs are held high regardless of the rail inputs. Otherwise the rails pass straight through. All flags are registered and change one clock after the bit strobe that causes the change.

Top module: `t1_alarm_detector`

## Requirements
- R1: Loss of signal (`los`) rises one clock after the bit strobe that carries the 128th consecutive received zero. Any received one restarts the zero run.
- R2: While `los` is high, `rail_p_out` and `rail_n_out` are both 1. While it is low, they equal `rail_p_in` and `rail_n_in`.
- R3: Bit strobes are grouped into windows of 386 bits (two frames), counted from the first strobe after reset. At the last bit of a window, `los` clears if that window held at least 48 ones. A window with 47 ones leaves it set.
- R4: At the frame start bit that follows two consecutive complete frames of all ones, `blue_alm` is set if `oof` is high at that bit.
- R5: With `oof` low, all-ones frames never set `blue_alm`.
- R6: Frame starts after the first one after reset are paired into 250 µs intervals of two frames. `blue_alm` clears at the frame start that ends an interval containing any zero, and holds until then.
- R7: At each frame start after the first, `yellow_alm` becomes 1 if no bit marked by `slot_b2` in the frame just ended was a 1, and 0 otherwise.
- R8: In extended superframe mode (`esf_mode` = 1), `esf_yellow` sets when the last sixteen data-link bits, oldest first, are eight ones and then eight zeros.
- R9: `esf_yellow` clears on the sixteenth consecutive data-link bit without that pattern, and one clock after `esf_mode` goes low. Data-link bits received with `esf_mode` low do not set it.
- R10: After reset, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: one received bit is present this cycle |
| rx_bit | input | 1 | Received bit value |
| frame_start | input | 1 | With bit_vld: this is the framing bit that opens a frame |
| slot_b2 | input | 1 | With bit_vld: this is bit position 2 of a DS0 channel |
| dl_vld | input | 1 | With bit_vld: this is a data-link bit |
| oof | input | 1 | Framer reports out of frame |
| esf_mode | input | 1 | 1 selects extended superframe operation |
| rail_p_in | input | 1 | Positive receive rail from the line interface |
| rail_n_in | input | 1 | Negative receive rail from the line interface |
| los | output | 1 | Loss of signal |
| blue_alm | output | 1 | Alarm indication signal (all ones while out of frame) |
| yellow_alm | output | 1 | Yellow alarm, channel bit 2 method |
| esf_yellow | output | 1 | Yellow alarm, data-link pattern method |
| rail_p_out | output | 1 | Positive rail, forced high during loss of signal |
| rail_n_out | output | 1 | Negative rail, forced high during loss of signal |

## Verification
A wrong zero-run count shows as `los` rising one bit early or late, so the checks sample exactly after the 127th and 128th zero. A misplaced density window or off-by-one ones threshold only shows at a window end, up to 386 bits later, which is why the bench runs windows with 47 and 48 ones. The frame-level state for the blue and yellow alarms becomes visible only at the next frame start, and the interval pairing for blue alarm clearing up to two frames after the offending zero; the pattern detector is probed with sequences whose shifted overlaps must not match.

// File: rtl/t1_alarm_detector.sv
module t1_alarm_detector #(
  parameter int FRAME_BITS  = 193,
  parameter int WIN_FRAMES  = 2,
  parameter int LOS_ZEROS   = 128,
  parameter int LOS_ONES    = 48,
  parameter int BLUE_FRAMES = 2,
  parameter int DL_LEN      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic frame_start,
  input  logic slot_b2,
  input  logic dl_vld,
  input  logic oof,
  input  logic esf_mode,
  input  logic rail_p_in,
  input  logic rail_n_in,
  output logic los,
  output logic blue_alm,
  output logic yellow_alm,
  output logic esf_yellow,
  output logic rail_p_out,
  output logic rail_n_out
);
  localparam int WIN_BITS = FRAME_BITS * WIN_FRAMES;
  localparam int WW = $clog2(WIN_BITS + 1);
  localparam int ZW = $clog2(LOS_ZEROS + 1);
  localparam int BW = $clog2(BLUE_FRAMES + 1);
  localparam int DW = $clog2(DL_LEN + 1);
  localparam logic [DL_LEN-1:0] DL_PAT = {{(DL_LEN/2){1'b1}}, {(DL_LEN - DL_LEN/2){1'b0}}};

  logic [WW-1:0] wpos, ones_cnt;
  logic [ZW-1:0] zrun;
  logic [BW-1:0] ones_run, ones_run_n;
  logic          seen_fs, fz, iz, half, b2one;
  logic [DL_LEN-1:0] dl_sh, dl_next;
  logic [DW-1:0] dl_miss;

  wire fs_hit  = bit_vld && frame_start;
  wire dl_hit  = bit_vld && dl_vld && esf_mode;
  wire win_end = (wpos == WW'(WIN_BITS - 1));
  wire [WW-1:0] ones_tot = ones_cnt + WW'(rx_bit);

  assign dl_next    = {dl_sh[DL_LEN-2:0], rx_bit};
  assign ones_run_n = fz ? '0 : (ones_run == BW'(BLUE_FRAMES) ? ones_run : ones_run + 1'b1);
  assign rail_p_out = rail_p_in | los;
  assign rail_n_out = rail_n_in | los;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpos <= '0; ones_cnt <= '0; zrun <= '0; los <= 1'b0;
    end else if (bit_vld) begin
      zrun <= rx_bit ? '0 : (zrun == ZW'(LOS_ZEROS) ? zrun : zrun + 1'b1);
      if (win_end) begin
        wpos <= '0;
        ones_cnt <= '0;
      end else begin
        wpos <= wpos + 1'b1;
        ones_cnt <= ones_tot;
      end
      if (!rx_bit && zrun == ZW'(LOS_ZEROS - 1))
        los <= 1'b1;
      else if (win_end && ones_tot >= WW'(LOS_ONES))
        los <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_fs <= 1'b0; fz <= 1'b0; iz <= 1'b0; half <= 1'b0; b2one <= 1'b0;
      ones_run <= '0; blue_alm <= 1'b0; yellow_alm <= 1'b0;
    end else if (fs_hit) begin
      seen_fs <= 1'b1;
      fz      <= !rx_bit;
      b2one   <= 1'b0;
      if (seen_fs) begin
        ones_run   <= ones_run_n;
        yellow_alm <= !b2one;
        half       <= !half;
        iz         <= half ? 1'b0 : (iz | fz);
        if (ones_run_n == BW'(BLUE_FRAMES) && oof)
          blue_alm <= 1'b1;
        else if (half && (iz || fz))
          blue_alm <= 1'b0;
      end
    end else if (bit_vld) begin
      if (!rx_bit) fz <= 1'b1;
      if (slot_b2 && rx_bit) b2one <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !esf_mode) begin
      dl_sh <= '0; dl_miss <= '0; esf_yellow <= 1'b0;
    end else if (dl_hit) begin
      dl_sh <= dl_next;
      if (dl_next == DL_PAT) begin
        esf_yellow <= 1'b1;
        dl_miss <= '0;
      end else if (dl_miss == DW'(DL_LEN - 1)) begin
        esf_yellow <= 1'b0;
        dl_miss <= '0;
      end else begin
        dl_miss <= dl_miss + 1'b1;
      end
    end
  end
endmodule

module t1_alarm_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic rx_bit,
  input logic frame_start,
  input logic dl_vld,
  input logic oof,
  input logic esf_mode,
  input logic los,
  input logic blue_alm,
  input logic yellow_alm,
  input logic esf_yellow,
  input logic rail_p_out,
  input logic rail_n_out
);
  a_r2_rails_forced: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> (rail_p_out && rail_n_out));
  a_r1_los_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bit_vld && !rx_bit));
  a_r3_los_fall_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(bit_vld));
  a_r4_blue_rise_needs_oof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blue_alm) |-> $past(oof && bit_vld && frame_start));
  a_r6_blue_moves_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blue_alm) |-> $past(bit_vld && frame_start));
  a_r7_yellow_moves_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(yellow_alm) |-> $past(bit_vld && frame_start));
  a_r8_esf_rise_on_dl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esf_yellow) |-> $past(esf_mode && bit_vld && dl_vld && !rx_bit));
endmodule

bind t1_alarm_detector t1_alarm_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
  .frame_start(frame_start), .dl_vld(dl_vld), .oof(oof), .esf_mode(esf_mode),
  .los(los), .blue_alm(blue_alm), .yellow_alm(yellow_alm), .esf_yellow(esf_yellow),
  .rail_p_out(rail_p_out), .rail_n_out(rail_n_out)
);

// File: tb/t1_alarm_detector_bench.sv
module t1_alarm_detector_bench;
  logic clk = 1'b0;
  logic rst_n, bit_vld, rx_bit, frame_start, slot_b2, dl_vld, oof, esf_mode, rail_p_in, rail_n_in;
  logic los, blue_alm, yellow_alm, esf_yellow, rail_p_out, rail_n_out;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  t1_alarm_detector u_t1_alarm_detector (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .frame_start(frame_start), .slot_b2(slot_b2), .dl_vld(dl_vld), .oof(oof),
    .esf_mode(esf_mode), .rail_p_in(rail_p_in), .rail_n_in(rail_n_in),
    .los(los), .blue_alm(blue_alm), .yellow_alm(yellow_alm), .esf_yellow(esf_yellow),
    .rail_p_out(rail_p_out), .rail_n_out(rail_n_out)
  );

  localparam int NV = 7;
  localparam logic [16:0] ESF_VEC [NV] = '{
    {16'hFF00, 1'b1}, {16'hFF00, 1'b1}, {16'hFFFF, 1'b0}, {16'hFF00, 1'b1},
    {16'h0000, 1'b0}, {16'hFE00, 1'b0}, {16'hFF00, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    bit_vld = 0; rx_bit = 0; frame_start = 0; slot_b2 = 0; dl_vld = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_bit(input logic v, input logic fs, input logic b2, input logic dl);
    bit_vld = 1; rx_bit = v; frame_start = fs; slot_b2 = b2; dl_vld = dl;
    @(negedge clk);
    idle();
  endtask

  task automatic frame(input int zpos, input logic [23:0] b2v, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      logic isb2, v;
      isb2 = (i >= 1) && (((i - 1) % 8) == 1);
      v = isb2 ? b2v[(i - 1) / 8] : 1'b1;
      if (i == zpos) v = 1'b0;
      send_bit(v, i == 0, isb2, 1'b0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    oof = 0; esf_mode = 1; rail_p_in = 0; rail_n_in = 0;
    do_reset();
    chk("R10 los", los, 0);
    chk("R10 blue", blue_alm, 0);
    chk("R10 yellow", yellow_alm, 0);
    chk("R10 esf", esf_yellow, 0);
    chk("R2 rail pass", rail_p_out, 0);

    for (int e = 0; e < NV; e++) begin
      for (int b = 15; b >= 0; b--) send_bit(ESF_VEC[e][b + 1], 1'b0, 1'b0, 1'b1);
      chk($sformatf("R8 R9 vector %0d", e), esf_yellow, ESF_VEC[e][0]);
    end
    esf_mode = 0;
    @(negedge clk);
    chk("R9 mode off clears", esf_yellow, 0);
    for (int b = 15; b >= 0; b--) send_bit(b >= 8, 1'b0, 1'b0, 1'b1);
    chk("R9 ignored when mode off", esf_yellow, 0);
    esf_mode = 1;

    do_reset();
    for (int i = 0; i < 127; i++) send_bit(0, 0, 0, 0);
    chk("R1 127 zeros", los, 0);
    send_bit(0, 0, 0, 0);
    chk("R1 128 zeros", los, 1);
    chk("R2 rail p forced", rail_p_out, 1);
    chk("R2 rail n forced", rail_n_out, 1);
    for (int i = 128; i < 386; i++) send_bit(0, 0, 0, 0);
    for (int i = 0; i < 386; i++) send_bit((i % 8 == 0) && (i / 8 < 47), 0, 0, 0);
    chk("R3 47 ones keeps los", los, 1);
    for (int i = 0; i < 385; i++) send_bit((i % 8 == 0) && (i / 8 < 48), 0, 0, 0);
    chk("R3 before window end", los, 1);
    send_bit(0, 0, 0, 0);
    chk("R3 48 ones clears", los, 0);
    rail_p_in = 1;
    @(negedge clk);
    chk("R2 rail follows input", rail_p_out, 1);
    chk("R2 rail n follows input", rail_n_out, 0);
    rail_p_in = 0;

    do_reset();
    oof = 1;
    frame(-1, 24'hFFFFFF, 0, 193);
    frame(-1, 24'hFFFFFF, 0, 1);
    chk("R4 one frame not enough", blue_alm, 0);
    frame(-1, 24'hFFFFFF, 1, 193);
    frame(-1, 24'hFFFFFF, 0, 1);
    chk("R4 blue set", blue_alm, 1);
    chk("R7 bit2 ones no yellow", yellow_alm, 0);
    frame(50, 24'hFFFFFF, 1, 193);
    frame(-1, 24'hFFFFFF, 0, 193);
    chk("R6 holds mid interval", blue_alm, 1);
    frame(-1, 24'hFFFFFF, 0, 1);
    chk("R6 clears at interval end", blue_alm, 0);

    do_reset();
    oof = 0;
    for (int f = 0; f < 3; f++) frame(-1, 24'hFFFFFF, 0, 193);
    frame(-1, 24'hFFFFFF, 0, 1);
    chk("R5 no blue in frame", blue_alm, 0);

    do_reset();
    frame(-1, 24'h000000, 0, 193);
    frame(-1, 24'h000000, 0, 1);
    chk("R7 yellow set", yellow_alm, 1);
    frame(-1, 24'h800000, 1, 193);
    frame(-1, 24'h000000, 0, 1);
    chk("R7 yellow clears", yellow_alm, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule